// File: doc/BRIEF.md
# Serial Frame Preamble Inserter

This block sits in the transmit path of a synchronous serial controller. It lies between the generator that fills the line between frames and the serializer that sends frame data. While no frame is pending, the line carries the timefill bit. When a new frame becomes ready and insertion is enabled, the block stops passing timefill. It then shifts out a programmable 8-bit pattern, LSB first, one bit per bit-clock enable, repeating the pattern 1 to 8 times. After that it gives the line to the frame serializer and marks the handover with a one-cycle done pulse.

With insertion disabled, a ready frame takes the line straight from timefill. The done pulse still tells the serializer to begin. The pattern bits go out exactly as programmed, so a receiver whose sync pattern equals the preamble can lock onto the preamble. The pattern and the repeat count are captured when the preamble starts. A frame-end strobe from the serializer returns the line to timefill.

Top module: `preamble_inserter`

## Requirements
- R1: After reset the block is in the timefill state: `line_out` equals `fill_bit`, and `pre_done`, `pre_active` and `frame_active` are 0. `pre_active` and `frame_active` are never high together.
- R2: In the timefill state `line_out` follows `fill_bit` combinationally.
- R3: In the timefill state, with `pre_en`=1, a `frame_ready` sampled high at a clock edge makes `pre_active`=1 from the next cycle, with `line_out` = bit 0 of the pattern.
- R4: During the preamble the pattern is shifted LSB first. The bit on the line advances only at a clock edge where `bit_tick` is 1, and it is held unchanged otherwise.
- R5: The pattern is sent `pre_reps`+1 times: field value 0 gives 1 repetition and 7 gives 8. The preamble therefore lasts exactly 8*(`pre_reps`+1) ticks.
- R6: Each repetition carries the pattern bits unaltered. `pre_pattern` and `pre_reps` are captured at the start, so later changes to them do not affect the preamble in progress.
- R7: The edge that consumes the final tick of the last repetition moves the block to the frame state. `pre_done` is high for exactly that one following cycle, `frame_active`=1, and `line_out` follows `frame_bit`.
- R8: With `pre_en`=0, a `frame_ready` accepted in the timefill state moves straight to the frame state on the next cycle. `pre_done` pulses there and no preamble bits are sent.
- R9: `frame_ready` is ignored outside the timefill state, both during the preamble and during the frame.
- R10: A `frame_end` sampled high in the frame state returns the block to timefill on the next cycle. In the other states `frame_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_en | input | 1 | Enable preamble insertion |
| pre_pattern | input | 8 | Preamble pattern, bit 0 sent first |
| pre_reps | input | 3 | Repetitions minus one |
| frame_ready | input | 1 | New frame waiting to be sent |
| frame_end | input | 1 | Serializer finished the frame |
| bit_tick | input | 1 | Bit-clock enable, one line bit per high cycle |
| fill_bit | input | 1 | Line bit from the timefill generator |
| frame_bit | input | 1 | Line bit from the frame serializer |
| line_out | output | 1 | Serial line data |
| pre_done | output | 1 | One-cycle pulse: serializer owns the line |
| pre_active | output | 1 | Preamble being shifted |
| frame_active | output | 1 | Frame serializer owns the line |

## Verification
The assertions assume that `frame_ready`, `frame_end` and `bit_tick` are synchronous to `clk` and that the configuration inputs have settled before the edge that accepts a frame. They place no limit on how `bit_tick` is spaced. The stimulus drives every input on the falling edge and holds it across the next rising edge. It varies the tick spacing between back-to-back ticks and ticks separated by idle cycles. It also changes the pattern, the repeat count and `frame_ready` in the middle of a preamble on purpose, to show that the captured values stay in force.

// File: rtl/pre_ins_pkg.sv
package pre_ins_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FRAME = 2'd2
  } pi_state_e;
endpackage

// File: rtl/pre_shift.sv
// Pattern shift register with bit index; reloads the captured pattern
// at the end of each repetition.
module pre_shift #(
  parameter int PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] pattern,
  input  logic             adv,
  output logic             bit_o,
  output logic             last_bit
);
  localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_W - 1);

  logic [PAT_W-1:0] pat_q;
  logic [PAT_W-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;

  assign last_bit = (idx_q == IDX_LAST);
  assign bit_o    = sh_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q <= '0;
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      pat_q <= pattern;
      sh_q  <= pattern;
      idx_q <= '0;
    end else if (adv) begin
      if (last_bit) begin
        sh_q  <= pat_q;
        idx_q <= '0;
      end else begin
        sh_q  <= sh_q >> 1;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R6: pattern copy is untouched while shifting
  p_pattern_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pat_q));
endmodule

// File: rtl/pre_rep_cnt.sv
// Counts completed repetitions against the captured limit.
module pre_rep_cnt #(
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REP_W-1:0] reps,
  input  logic             step,
  output logic             final_rep
);
  logic [REP_W-1:0] cnt_q;
  logic [REP_W-1:0] lim_q;

  assign final_rep = (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= reps;
    end else if (step && !final_rep) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_rep_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/pre_ctrl.sv
// Line ownership state machine.
module pre_ctrl
  import pre_ins_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pre_en,
  input  logic      frame_ready,
  input  logic      frame_end,
  input  logic      bit_tick,
  input  logic      last_bit,
  input  logic      final_rep,
  output logic      load,
  output logic      adv,
  output logic      done,
  output pi_state_e state
);
  pi_state_e state_q, state_d;
  logic      done_d;
  logic      finish;

  assign state  = state_q;
  assign load   = (state_q == ST_FILL) && frame_ready && pre_en;
  assign adv    = (state_q == ST_PRE) && bit_tick;
  assign finish = adv && last_bit && final_rep;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_FILL: if (frame_ready) begin
        if (pre_en) state_d = ST_PRE;
        else begin
          state_d = ST_FRAME;
          done_d  = 1'b1;
        end
      end
      ST_PRE: if (finish) begin
        state_d = ST_FRAME;
        done_d  = 1'b1;
      end
      ST_FRAME: if (frame_end) state_d = ST_FILL;
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == ST_FRAME));
endmodule

// File: rtl/preamble_inserter.sv
module preamble_inserter
  import pre_ins_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_en,
  input  logic [PAT_W-1:0] pre_pattern,
  input  logic [REP_W-1:0] pre_reps,
  input  logic             frame_ready,
  input  logic             frame_end,
  input  logic             bit_tick,
  input  logic             fill_bit,
  input  logic             frame_bit,
  output logic             line_out,
  output logic             pre_done,
  output logic             pre_active,
  output logic             frame_active
);
  pi_state_e state;
  logic      load, adv, last_bit, final_rep, pat_bit;

  pre_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .frame_ready(frame_ready),
    .frame_end(frame_end), .bit_tick(bit_tick), .last_bit(last_bit),
    .final_rep(final_rep), .load(load), .adv(adv), .done(pre_done),
    .state(state)
  );

  pre_shift #(.PAT_W(PAT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .pattern(pre_pattern),
    .adv(adv), .bit_o(pat_bit), .last_bit(last_bit)
  );

  pre_rep_cnt #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .load(load), .reps(pre_reps),
    .step(adv && last_bit), .final_rep(final_rep)
  );

  assign pre_active   = (state == ST_PRE);
  assign frame_active = (state == ST_FRAME);

  always_comb begin
    unique case (state)
      ST_PRE:   line_out = pat_bit;
      ST_FRAME: line_out = frame_bit;
      default:  line_out = fill_bit;
    endcase
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_active, frame_active}));
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_active && !frame_active && frame_ready && pre_en) |=> pre_active);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_active && !bit_tick) |=> (pre_active && $stable(line_out)));
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_active && !frame_active && frame_ready && !pre_en)
      |=> (frame_active && pre_done));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !frame_end) |=> (frame_active && !pre_done));
  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && frame_end) |=> (!frame_active && !pre_active));
endmodule

// File: tb/preamble_inserter_bench.sv
module preamble_inserter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_en = 1'b0;
  logic [7:0] pre_pattern = 8'h00;
  logic [2:0] pre_reps = 3'd0;
  logic       frame_ready = 1'b0;
  logic       frame_end = 1'b0;
  logic       bit_tick = 1'b0;
  logic       fill_bit = 1'b0;
  logic       frame_bit = 1'b1;
  logic       line_out, pre_done, pre_active, frame_active;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  preamble_inserter u_preamble_inserter (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_pattern(pre_pattern),
    .pre_reps(pre_reps), .frame_ready(frame_ready), .frame_end(frame_end),
    .bit_tick(bit_tick), .fill_bit(fill_bit), .frame_bit(frame_bit),
    .line_out(line_out), .pre_done(pre_done), .pre_active(pre_active),
    .frame_active(frame_active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pre_done == 0, "R1", "done after reset", 32'(pre_done), 0);
    chk(pre_active == 0 && frame_active == 0, "R1", "state after reset",
        {pre_active, frame_active}, 0);
    chk(line_out == fill_bit, "R1", "line after reset", 32'(line_out), 32'(fill_bit));
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) begin
      fill_bit = i[0];
      #1;
      chk(line_out == fill_bit, "R2", "timefill follow", 32'(line_out), 32'(fill_bit));
      @(negedge clk);
    end
    fill_bit = 1'b0;
    // R10: frame_end outside a frame does nothing
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(!pre_active && !frame_active && !pre_done, "R10", "frame_end in fill",
        {pre_active, frame_active, pre_done}, 0);
  endtask

  // Starts a preamble and follows it to the handover.
  task automatic t_preamble(input logic [7:0] pat, input logic [2:0] reps,
                            input int gap, input bit disturb);
    pre_en = 1'b1;
    pre_pattern = pat;
    pre_reps = reps;
    frame_ready = 1'b1;
    @(negedge clk);
    frame_ready = 1'b0;
    chk(pre_active == 1, "R3", "preamble started", 32'(pre_active), 1);
    chk(line_out == pat[0], "R3", "first bit", 32'(line_out), 32'(pat[0]));
    for (int r = 0; r <= int'(reps); r++) begin
      for (int b = 0; b < 8; b++) begin
        for (int g = 0; g < gap; g++) begin
          bit_tick = 1'b0;
          @(negedge clk);
          chk(line_out == pat[b], "R4", "hold without tick", 32'(line_out), 32'(pat[b]));
        end
        chk(line_out == pat[b], "R6", "pattern bit", 32'(line_out), 32'(pat[b]));
        chk(pre_done == 0 && pre_active == 1, "R5", "still in preamble",
            {pre_done, pre_active}, 1);
        frame_ready = disturb && r == 0 && b == 3;
        if (disturb && r == 0 && b == 3) begin
          pre_pattern = ~pat;
          pre_reps = ~reps;
        end
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        frame_ready = 1'b0;
      end
    end
    chk(pre_done == 1, "R7", "done pulse", 32'(pre_done), 1);
    chk(frame_active == 1 && pre_active == 0, "R5", "handover after count",
        {pre_active, frame_active}, 1);
    frame_bit = 1'b1;
    #1;
    chk(line_out == 1'b1, "R7", "line to serializer", 32'(line_out), 1);
    frame_bit = 1'b0;
    #1;
    chk(line_out == 1'b0, "R7", "line to serializer", 32'(line_out), 0);
    @(negedge clk);
    chk(pre_done == 0, "R7", "done one cycle", 32'(pre_done), 0);
  endtask

  task automatic t_ignore_in_frame();
    frame_ready = 1'b1;
    @(negedge clk);
    frame_ready = 1'b0;
    chk(frame_active == 1 && pre_active == 0 && pre_done == 0, "R9",
        "frame_ready in frame", {frame_active, pre_active, pre_done}, 3'b100);
  endtask

  task automatic t_end_frame();
    fill_bit = 1'b1;
    frame_bit = 1'b0;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk(frame_active == 0 && pre_active == 0, "R10", "back to fill",
        {frame_active, pre_active}, 0);
    chk(line_out == 1'b1, "R10", "line follows fill", 32'(line_out), 1);
    fill_bit = 1'b0;
  endtask

  task automatic t_bypass();
    pre_en = 1'b0;
    frame_bit = 1'b1;
    frame_ready = 1'b1;
    @(negedge clk);
    frame_ready = 1'b0;
    chk(frame_active == 1 && pre_active == 0, "R8", "direct to frame",
        {frame_active, pre_active}, 2'b10);
    chk(pre_done == 1, "R8", "done in bypass", 32'(pre_done), 1);
    chk(line_out == 1'b1, "R8", "line from serializer", 32'(line_out), 1);
    @(negedge clk);
    chk(pre_done == 0, "R8", "bypass done one cycle", 32'(pre_done), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_preamble(8'hB4, 3'd0, 0, 1'b0);
    t_ignore_in_frame();
    t_end_frame();
    t_preamble(8'h5C, 3'd2, 2, 1'b1);
    t_end_frame();
    t_preamble(8'hE1, 3'd7, 0, 1'b1);
    t_end_frame();
    t_bypass();
    t_ignore_in_frame();
    t_end_frame();
    t_preamble(8'h01, 3'd1, 1, 1'b0);
    t_end_frame();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule